// File: doc/BRIEF.md
# GPIO Port with Hardware Blink and Input Inversion

A 32-pin general-purpose I/O port controlled through a small synchronous register port. Four writable registers hold the per-pin output level, pin direction, blink enable and input inversion. A fifth register is read-only. It returns the synchronized pin values, each XORed with its inversion bit. The port drives an output-enable and an output value for every pin.

A pin whose blink bit is set toggles its output on a shared blink phase. The phase flips once every `HALF_CYCLES` clock cycles, which is the clock count for 100 ms on the target clock. Every blinking pin uses the same phase. Firmware is expected to clear a pin's level bit before it enables blink on that pin. It is also expected to clear the blink bit before it drives a fixed level on the pin.

The register port carries no streamed data, so it has no valid/ready handshake. A write happens on the rising clock edge in which `bus_we` is high. A read is combinational from `bus_addr`. There is no back-pressure.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (all pins are inputs), and the level, blink and inversion registers read 0. `pin_oe` and `pin_out` are all zero.
- R2: The direction register is at byte offset 0x04 and can be read and written. A direction bit of 1 makes its pin an input (`pin_oe` low). A direction bit of 0 makes it a driven output (`pin_oe` high).
- R3: The level register is at offset 0x00 and can be read and written. On a pin whose blink bit is 0, `pin_out` equals the level bit.
- R4: The data-in register is at offset 0x10. It reads the pin value after a two-flop synchronizer, XORed with the inversion register at offset 0x0C. A change on `pin_in` first shows up in the second read cycle after the clock edge that samples it.
- R5: A single shared blink phase starts low at reset and flips once every `HALF_CYCLES` clock cycles.
- R6: A pin whose blink bit is set (blink register at offset 0x08) and whose level bit is 0 drives the blink phase on `pin_out`. All such pins are equal at every cycle.
- R7: A pin whose blink bit is set and whose level bit is 1 drives `pin_out` high at all times.
- R8: Writes to the data-in offset and to unmapped offsets change no register. Reads from unmapped offsets return 0.
- R9: A register write is visible on `bus_rdata` in the cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Raw pin input levels |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |

## Verification
The bench measures synchronizer latency by reading data-in in each cycle after a pin change. A design with one stage too few or too many shows the new value a cycle early or late. The bench times the gap between blink transitions against `HALF_CYCLES`, which exposes an off-by-one in the prescaler. It also compares two blinking pins to each other, which catches a design with per-pin phases. A blinking pin with its level bit at 1 must stay high, so a design that ANDs the level with the phase would fail. Writes to data-in and to unmapped offsets are followed by a full read-back, which catches decoders that alias a register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS   = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_BLINK = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_INV   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIN   = 5'h10;

  typedef struct packed {
    logic [PINS-1:0] level;
    logic [PINS-1:0] dir;
    logic [PINS-1:0] blink;
    logic [PINS-1:0] inv;
  } gpio_cfg_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  input  logic              we,
  input  logic [PINS-1:0]   din_view,
  output logic [PINS-1:0]   rdata,
  output gpio_cfg_t         cfg
);
  gpio_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.level <= '0;
      cfg_q.dir   <= '1;
      cfg_q.blink <= '0;
      cfg_q.inv   <= '0;
    end else if (we) begin
      case (addr)
        OFF_LEVEL: cfg_q.level <= wdata;
        OFF_DIR:   cfg_q.dir   <= wdata;
        OFF_BLINK: cfg_q.blink <= wdata;
        OFF_INV:   cfg_q.inv   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFF_LEVEL: rdata = cfg_q.level;
      OFF_DIR:   rdata = cfg_q.dir;
      OFF_BLINK: rdata = cfg_q.blink;
      OFF_INV:   rdata = cfg_q.inv;
      OFF_DIN:   rdata = din_view;
      default:   rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

  // R2: a direction write is taken on the next edge
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_DIR) |=> cfg_q.dir == $past(wdata));

  // R8: a write to data-in leaves every stored register alone
  a_r8_din_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_DIN) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_blink_tick.sv
module gpio_blink_tick #(
  parameter int HALF_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = $clog2(HALF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the prescaler never runs past its half period
  always @(posedge clk) begin
    if (rst_n) a_r5_cnt_bound: assert (cnt < CNT_W'(HALF_CYCLES));
  end

  // R5: the phase flips only after the last count of a half period
  a_r5_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(cnt) == LAST);
endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
  import gpio_pkg::*;
#(
  parameter int HALF_CYCLES = 10_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);
  gpio_cfg_t       cfg;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] din_view;
  logic            phase;

  gpio_insync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign din_view = pin_sync ^ cfg.inv;

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .din_view(din_view), .rdata(bus_rdata), .cfg(cfg)
  );

  gpio_blink_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .phase(phase)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pad
    assign pin_oe[p]  = ~cfg.dir[p];
    assign pin_out[p] = cfg.blink[p] ? (cfg.level[p] | phase) : cfg.level[p];
  end

  // R7: a blinking pin with its level bit set never drives low
  always @(posedge clk) begin
    if (rst_n) a_r7_level_holds_high: assert (((cfg.blink & cfg.level) & ~pin_out) == '0);
  end

  // R6: all blinking pins with level 0 move together with the shared phase
  a_r6_shared_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ {PINS{phase}}) & (cfg.blink & ~cfg.level)) == '0);
endmodule

// File: tb/sim_gpio_blink_port.sv
module sim_gpio_blink_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe;
  logic [31:0] pin_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_blink_port #(.HALF_CYCLES(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // {addr, write data, expected read-back}
  localparam logic [68:0] VEC [0:5] = '{
    {5'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {5'h04, 32'h0000_FFFF, 32'h0000_FFFF},
    {5'h08, 32'h0000_0000, 32'h0000_0000},
    {5'h0C, 32'h1234_5678, 32'h1234_5678},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h1C, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    logic last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h04, v); check("R1 dir", v, 32'hFFFF_FFFF);
    rd(5'h00, v); check("R1 level", v, 32'h0);
    rd(5'h08, v); check("R1 blink", v, 32'h0);
    rd(5'h0C, v); check("R1 inv", v, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);

    // R9 / R8 register table walk
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      check("R9 R8 table readback", v, VEC[i][31:0]);
    end

    // R2, R3 pads after the table
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    check("R3 pin_out level", pin_out & pin_oe, 32'hA5A5_0000);

    // R8 data-in and unmapped writes change nothing
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0);
    rd(5'h00, v); check("R8 level kept", v, 32'hA5A5_0F0F);
    rd(5'h04, v); check("R8 dir kept", v, 32'h0000_FFFF);
    rd(5'h08, v); check("R8 blink kept", v, 32'h0);
    rd(5'h0C, v); check("R8 inv kept", v, 32'h1234_5678);

    // R4 synchronizer latency and inversion
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk); @(negedge clk);
    pin_in = 32'h0000_00F0;
    rd(5'h10, v); check("R4 before edge", v, 32'h0);
    @(negedge clk);
    rd(5'h10, v); check("R4 one edge", v, 32'h0);
    @(negedge clk);
    rd(5'h10, v); check("R4 two edges", v, 32'h0000_00F0);
    wr(5'h0C, 32'h0000_00FF);
    rd(5'h10, v); check("R4 inverted", v, 32'h0000_000F);

    // R5 R6 R7 blink
    wr(5'h00, 32'h0000_0020);
    wr(5'h04, ~32'h0000_0228);
    wr(5'h08, 32'h0000_0228);
    last = pin_out[3];
    n = 0;
    while (pin_out[3] == last && n < 4 * HALF) begin
      @(negedge clk); n++;
    end
    for (int k = 0; k < 3; k++) begin
      last = pin_out[3];
      n = 0;
      while (pin_out[3] == last && n < 4 * HALF) begin
        @(negedge clk); n++;
        check("R6 shared phase", {31'b0, pin_out[9]}, {31'b0, pin_out[3]});
        check("R7 level high", {31'b0, pin_out[5]}, 32'h1);
      end
      check("R5 half period", n, HALF);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule